// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs. A processor reaches it through a small word-addressed register bus. The processor places a 16-bit register address and a 16-bit write value in holding registers. It then writes a command word with the start bit set. The block turns that command into one serial management frame on a clock/data pin pair. Each frame starts with a run of preamble ones. The raw clause and operation codes of the command go onto the wire unchanged, so a single command register serves both the short-address (Clause 22) and the extended-address (Clause 45) frame families.

The start bit stays set while a frame is in flight, so it doubles as the busy flag. During a read, the block releases the data pin from the first turnaround bit to the end of the frame. It checks that the PHY pulls the second turnaround bit low, and shifts the returned 16 bits into a read-data register. A failed turnaround sets a status bit. That bit holds until the next accepted command.

Top module: `mdio_master`

## Requirements
- R1: After reset, every readable register returns 0, `mdc` is low and `mdio_oe` is low.
- R2: Command word bits 4:0 hold the register/device address, bits 9:5 the port address, bits 11:10 the operation code, bits 13:12 the clause code and bit 14 the start bit. An accepted command sends 32 ones, then clause code, operation code, port address and register/device address, each MSB first.
- R3: For a frame whose operation code bit 1 is 0, the block drives turnaround bits 1 then 0, followed by the 16-bit write-data register, MSB first.
- R4: For a frame whose operation code bit 1 is 1 (read), `mdio_oe` is low from the first turnaround bit through the last data bit. The 16 bits sampled on the rising edges of `mdc` appear, MSB first, in bits 15:0 of the read-data register (offset 0xC) by the time the start bit clears.
- R5: When the clause code is 0 (Clause 45) and the operation code is 0 (address), the 16-bit data field carries the address register (offset 0x4) instead of the write-data register.
- R6: A write to offset 0x0 with bit 14 set starts a frame. Bit 14 of offset 0x0 then reads 1, together with the stored fields, and returns to 0 exactly 128 × `HALF_DIV` clock cycles after the accepting edge.
- R7: A command write that arrives while bit 14 still reads 1 is ignored, including one in the very cycle the frame completes. The stored fields stay unchanged and no frame is sent.
- R8: Status bit 0 (offset 0x10) becomes 1 after a read whose second turnaround bit was sampled as 1. It stays 0 after a read that saw 0.
- R9: Every accepted command clears status bit 0 in the cycle after it is accepted.
- R10: `mdc` stays high for `HALF_DIV` cycles and low for `HALF_DIV` cycles, and is low while idle. `mdio_o` and `mdio_oe` change during a frame only on a falling edge of `mdc`.
- R11: The address (0x4) and write-data (0x8) registers read back their 16-bit values. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin sampled value |

## Verification
A command write can land in the same cycle as the final falling edge of `mdc`, which ends a frame. In that cycle the start bit still reads 1, so the write must be dropped. The bench times a conflicting command write to hit that completion edge exactly: it counts 128 × `HALF_DIV` cycles from the edge that accepted the previous command. Right after that it issues a legal command. The scoreboard must then see only the legal frame, and the command register must show the legal command's fields.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int OFS_CMD    = 'h00;
    localparam int OFS_ADDR   = 'h04;
    localparam int OFS_WDATA  = 'h08;
    localparam int OFS_RDATA  = 'h0C;
    localparam int OFS_STATUS = 'h10;

    localparam int FIELD_W    = 16;
    localparam int START_BIT  = 14;

    // Bit order of this struct matches the command word bits 13:0.
    typedef struct packed {
        logic [1:0] clause;
        logic [1:0] opc;
        logic [4:0] port;
        logic [4:0] reg_dev;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [FIELD_W-1:0] rd_data,
    input  logic              ta_err,
    output logic              launch,
    output mdio_cmd_t         cmd,
    output logic [FIELD_W-1:0] addr_reg,
    output logic [FIELD_W-1:0] wdata_reg,
    output logic              fail
);

    typedef struct packed {
        mdio_cmd_t          cmd;
        logic [FIELD_W-1:0] addr;
        logic [FIELD_W-1:0] wdat;
        logic [FIELD_W-1:0] rdat;
        logic               fail;
    } regs_t;

    regs_t regs_d, regs_q;

    logic sel_cmd, sel_addr, sel_wdat, sel_rdat, sel_stat;
    logic unused_hi;

    assign sel_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
    assign sel_addr = (bus_addr == ADDR_W'(OFS_ADDR));
    assign sel_wdat = (bus_addr == ADDR_W'(OFS_WDATA));
    assign sel_rdat = (bus_addr == ADDR_W'(OFS_RDATA));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STATUS));
    assign unused_hi = ^bus_wdata[BUS_W-1:START_BIT+1];

    // Only a command write with the start bit set, while idle, launches a frame.
    assign launch = bus_we && sel_cmd && bus_wdata[START_BIT] && !busy;

    always_comb begin
        regs_d = regs_q;
        if (launch) begin
            regs_d.cmd  = mdio_cmd_t'(bus_wdata[START_BIT-1:0]);
            regs_d.fail = 1'b0;
        end
        if (bus_we && sel_addr) regs_d.addr = bus_wdata[FIELD_W-1:0];
        if (bus_we && sel_wdat) regs_d.wdat = bus_wdata[FIELD_W-1:0];
        if (done && regs_q.cmd.opc[1]) begin
            regs_d.rdat = rd_data;
            regs_d.fail = ta_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_cmd) begin
            bus_rdata[START_BIT]     = busy;
            bus_rdata[START_BIT-1:0] = regs_q.cmd;
        end else if (sel_addr) begin
            bus_rdata[FIELD_W-1:0] = regs_q.addr;
        end else if (sel_wdat) begin
            bus_rdata[FIELD_W-1:0] = regs_q.wdat;
        end else if (sel_rdat) begin
            bus_rdata[FIELD_W-1:0] = regs_q.rdat;
        end else if (sel_stat) begin
            bus_rdata[0] = regs_q.fail;
        end
    end

    assign cmd       = regs_q.cmd;
    assign addr_reg  = regs_q.addr;
    assign wdata_reg = regs_q.wdat;
    assign fail      = regs_q.fail;

endmodule

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t div_d, div_q;
    logic tick;

    assign tick = en && (div_q.cnt == CNT_W'(HALF_DIV - 1));
    assign rise = tick && !div_q.mdc;
    assign fall = tick &&  div_q.mdc;

    always_comb begin
        div_d = div_q;
        if (!en) begin
            div_d = '0;
        end else if (tick) begin
            div_d.cnt = '0;
            div_d.mdc = !div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc = div_q.mdc;

endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  mdio_cmd_t          cmd_in,
    input  logic [FIELD_W-1:0] addr_reg,
    input  logic [FIELD_W-1:0] wdata_reg,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_i,
    output logic               busy,
    output logic               done,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [FIELD_W-1:0] rd_data,
    output logic               ta_err
);

    localparam int HDR_BITS = $bits(mdio_cmd_t);
    localparam int FRAME    = PRE_BITS + HDR_BITS + 2 + FIELD_W;
    localparam int IDX_W    = $clog2(FRAME);
    localparam int TA_FIRST = PRE_BITS + HDR_BITS;
    localparam int TA_LAST  = TA_FIRST + 1;
    localparam int DAT_FIRST = TA_FIRST + 2;

    typedef struct packed {
        logic               busy;
        logic               rd;
        logic [IDX_W-1:0]   idx;
        logic [FRAME-1:0]   sh;
        logic [FIELD_W-1:0] rdsh;
        logic               ta_err;
    } shf_t;

    shf_t shf_d, shf_q;

    logic               is_rd;
    logic               addr_frame;
    logic [1:0]         ta_bits;
    logic [FIELD_W-1:0] data_bits;
    logic               last_bit;

    assign is_rd      = cmd_in.opc[1];
    assign addr_frame = (cmd_in.clause == 2'd0) && (cmd_in.opc == 2'd0);
    assign ta_bits    = is_rd ? 2'b11 : 2'b10;
    assign data_bits  = is_rd ? '1 : (addr_frame ? addr_reg : wdata_reg);
    assign last_bit   = (shf_q.idx == IDX_W'(FRAME - 1));

    always_comb begin
        shf_d = shf_q;
        done  = 1'b0;
        if (launch) begin
            shf_d.busy   = 1'b1;
            shf_d.rd     = is_rd;
            shf_d.idx    = '0;
            shf_d.sh     = {{PRE_BITS{1'b1}}, cmd_in, ta_bits, data_bits};
            shf_d.rdsh   = '0;
            shf_d.ta_err = 1'b0;
        end else if (shf_q.busy) begin
            if (rise && shf_q.rd) begin
                if (shf_q.idx == IDX_W'(TA_LAST)) begin
                    shf_d.ta_err = mdio_i;
                end
                if (shf_q.idx >= IDX_W'(DAT_FIRST)) begin
                    shf_d.rdsh = {shf_q.rdsh[FIELD_W-2:0], mdio_i};
                end
            end
            if (fall) begin
                if (last_bit) begin
                    shf_d.busy = 1'b0;
                    done       = 1'b1;
                end else begin
                    shf_d.idx = shf_q.idx + IDX_W'(1);
                    shf_d.sh  = {shf_q.sh[FRAME-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign busy    = shf_q.busy;
    assign mdio_o  = shf_q.sh[FRAME-1];
    assign mdio_oe = shf_q.busy && !(shf_q.rd && (shf_q.idx >= IDX_W'(TA_FIRST)));
    assign rd_data = shf_q.rdsh;
    assign ta_err  = shf_q.ta_err;

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int BUS_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic               busy, done, launch, ta_err, fail;
    logic               rise, fall;
    mdio_cmd_t          cmd_cur;
    logic [FIELD_W-1:0] addr_reg, wdata_reg, rd_data;

    mdio_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .ta_err    (ta_err),
        .launch    (launch),
        .cmd       (cmd_cur),
        .addr_reg  (addr_reg),
        .wdata_reg (wdata_reg),
        .fail      (fail)
    );

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_shifter #(.PRE_BITS(PRE_BITS)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd_in    (cmd_cur_next(bus_wdata)),
        .addr_reg  (addr_reg),
        .wdata_reg (wdata_reg),
        .rise      (rise),
        .fall      (fall),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data),
        .ta_err    (ta_err)
    );

    // The shifter loads the frame in the accepting cycle, so it takes the
    // fields straight from the bus word rather than the stored copy.
    function automatic mdio_cmd_t cmd_cur_next(input logic [BUS_W-1:0] w);
        return mdio_cmd_t'(w[START_BIT-1:0]);
    endfunction

endmodule

// File: rtl/mdio_master_sva.sv
`timescale 1ns/1ps
module mdio_master_sva #(
    parameter int HALF_DIV = 2,
    parameter int ADDR_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              start_bit,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic [13:0]       cmd_bits,
    input logic              fail
);

    logic        cmd_wr;
    logic [15:0] hi_cnt;

    assign cmd_wr = bus_we && (bus_addr == '0) && start_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_cnt <= '0;
        else if (!mdc)         hi_cnt <= '0;
        else if (hi_cnt != '1) hi_cnt <= hi_cnt + 16'd1;
    end

    // R6: an accepted command raises the start/busy flag
    p_launch_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !busy |=> busy);

    // R7: a command during a frame leaves the stored fields alone
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && busy |=> $stable(cmd_bits));

    // R9: an accepted command clears the failure flag
    p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !busy |=> !fail);

    // R10: the management clock rests low between frames
    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R10: data pin only moves on a falling management clock edge
    p_pin_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

    // R10: high phase of the management clock lasts HALF_DIV cycles
    p_mdc_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> hi_cnt == 16'(HALF_DIV));

endmodule

bind mdio_master mdio_master_sva #(.HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .start_bit (bus_wdata[14]),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .cmd_bits  (cmd_cur),
    .fail      (fail)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

    localparam int HALF      = 2;
    localparam int FBITS     = 64;
    localparam int FRAME_CYC = FBITS * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int frames_sent = 0;
    bit done_flag = 0;

    logic        phy_drv = 1'b0;
    logic        phy_val = 1'b1;
    logic [15:0] phy_data = '0;
    logic        phy_ta_bad = 1'b0;
    logic [15:0] shadow_addr = '0;
    logic [15:0] shadow_wdat = '0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_master #(.HALF_DIV(HALF)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: PHY responder plus scoreboard comparison of every frame.
    int          rc = 0;
    logic [63:0] cap = '0;
    always @(posedge mdc or negedge mdc) begin
        if (mdc) begin
            cap[63-rc] = mdio_i;
            rc++;
            if (rc == FBITS) begin
                frames_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected frame", cap, 64'h0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cap == e, t, cap, e);
                end
            end
        end else begin
            if (rc == FBITS) begin
                rc = 0;
                phy_drv = 1'b0;
            end else if (cap[63-34] && rc >= 47) begin
                phy_drv = 1'b1;
                phy_val = (rc == 47) ? phy_ta_bad : phy_data[15-(rc-48)];
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] st, input logic [1:0] op,
                                             input logic [4:0] prt, input logic [4:0] dv);
        return {17'b0, 1'b1, st, op, prt, dv};
    endfunction

    // Driver: pushes the expected frame, then writes the command.
    task automatic issue(input logic [1:0] st, input logic [1:0] op, input logic [4:0] prt,
                         input logic [4:0] dv, input logic [15:0] pdata, input logic ta_bad,
                         input string tag);
        logic [1:0]  ta;
        logic [15:0] dat;
        if (op[1]) begin
            ta  = {1'b1, ta_bad};
            dat = pdata;
        end else begin
            ta  = 2'b10;
            dat = (st == 2'd0 && op == 2'd0) ? shadow_addr : shadow_wdat;
        end
        exp_q.push_back({32'hFFFF_FFFF, st, op, prt, dv, ta, dat});
        tag_q.push_back(tag);
        phy_data   = pdata;
        phy_ta_bad = ta_bad;
        frames_sent++;
        bus_write(5'h00, cmd_word(st, op, prt, dv));
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int i = 0; i < 5000; i++) begin
            bus_read(5'h00, r);
            if (!r[14]) return;
        end
        chk(1'b0, "R6 start bit never cleared", 64'(r), 64'h0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h00, r); chk(r == 0, "R1 cmd reset", 64'(r), 0);
        bus_read(5'h0C, r); chk(r == 0, "R1 rdata reset", 64'(r), 0);
        bus_read(5'h10, r); chk(r == 0, "R1 status reset", 64'(r), 0);
        chk(!mdc && !mdio_oe, "R1 pins idle", {62'b0, mdc, mdio_oe}, 0);

        // R11 holding registers
        bus_write(5'h04, 32'hFFFF_A5C3); shadow_addr = 16'hA5C3;
        bus_write(5'h08, 32'h0000_3C5A); shadow_wdat = 16'h3C5A;
        bus_read(5'h04, r); chk(r == 32'hA5C3, "R11 addr readback", 64'(r), 64'hA5C3);
        bus_read(5'h08, r); chk(r == 32'h3C5A, "R11 wdata readback", 64'(r), 64'h3C5A);
        bus_read(5'h14, r); chk(r == 0, "R11 unmapped offset", 64'(r), 0);

        // R2 R3 short-address write; R6 busy readback
        issue(2'd1, 2'd1, 5'h11, 5'h04, 16'h0, 1'b0, "R2 R3 C22 write frame");
        bus_read(5'h00, r);
        chk(r == cmd_word(2'd1, 2'd1, 5'h11, 5'h04), "R6 busy readback", 64'(r),
            64'(cmd_word(2'd1, 2'd1, 5'h11, 5'h04)));
        wait_idle();
        bus_read(5'h00, r); chk(r[14] == 1'b0, "R6 start bit clears", 64'(r[14]), 0);

        // R4 short-address read; R8 clean turnaround
        issue(2'd1, 2'd2, 5'h03, 5'h1F, 16'hBEEF, 1'b0, "R4 C22 read frame");
        wait_idle();
        bus_read(5'h0C, r); chk(r == 32'hBEEF, "R4 C22 read data", 64'(r), 64'hBEEF);
        bus_read(5'h10, r); chk(r == 0, "R8 good read status", 64'(r), 0);

        // R5 extended address frame, R3 extended write, R4 extended reads
        issue(2'd0, 2'd0, 5'h1A, 5'h07, 16'h0, 1'b0, "R5 C45 address frame");
        wait_idle();
        issue(2'd0, 2'd1, 5'h1A, 5'h07, 16'h0, 1'b0, "R3 C45 write frame");
        wait_idle();
        issue(2'd0, 2'd3, 5'h02, 5'h01, 16'h1234, 1'b0, "R4 C45 read frame");
        wait_idle();
        bus_read(5'h0C, r); chk(r == 32'h1234, "R4 C45 read data", 64'(r), 64'h1234);
        issue(2'd0, 2'd2, 5'h02, 5'h01, 16'h8001, 1'b0, "R4 C45 read-inc frame");
        wait_idle();
        bus_read(5'h0C, r); chk(r == 32'h8001, "R4 C45 read-inc data", 64'(r), 64'h8001);

        // R10 clock phases
        issue(2'd1, 2'd1, 5'h05, 5'h05, 16'h0, 1'b0, "R10 timing frame");
        @(posedge mdc);
        n = 0; @(negedge clk);
        while (mdc) begin n++; @(negedge clk); end
        chk(n == HALF, "R10 mdc high time", 64'(n), 64'(HALF));
        n = 0;
        while (!mdc) begin n++; @(negedge clk); end
        chk(n == HALF, "R10 mdc low time", 64'(n), 64'(HALF));
        wait_idle();

        // R7 command while busy ignored
        issue(2'd1, 2'd2, 5'h09, 5'h02, 16'h5AA5, 1'b0, "R7 frame before ignored cmd");
        repeat (20) @(negedge clk);
        bus_write(5'h00, cmd_word(2'd0, 2'd1, 5'h1E, 5'h1E));
        bus_read(5'h00, r);
        chk(r == cmd_word(2'd1, 2'd2, 5'h09, 5'h02), "R7 fields kept while busy", 64'(r),
            64'(cmd_word(2'd1, 2'd2, 5'h09, 5'h02)));
        wait_idle();

        // R7 command in the completion cycle ignored
        issue(2'd1, 2'd1, 5'h0C, 5'h0D, 16'h0, 1'b0, "R7 frame before collision");
        repeat (FRAME_CYC - 2) @(negedge clk);
        bus_write(5'h00, cmd_word(2'd0, 2'd3, 5'h15, 5'h15));
        issue(2'd1, 2'd2, 5'h0E, 5'h0F, 16'h0F0F, 1'b0, "R7 frame after collision");
        wait_idle();
        bus_read(5'h00, r);
        chk(r == cmd_word(2'd1, 2'd2, 5'h0E, 5'h0F) - 32'h4000, "R7 collision fields", 64'(r),
            64'(cmd_word(2'd1, 2'd2, 5'h0E, 5'h0F) - 32'h4000));

        // R8 bad turnaround flagged
        issue(2'd1, 2'd2, 5'h01, 5'h01, 16'hC0DE, 1'b1, "R8 bad-turnaround frame");
        wait_idle();
        bus_read(5'h10, r); chk(r == 1, "R8 failure flagged", 64'(r), 1);

        // R9 next command clears failure
        issue(2'd1, 2'd1, 5'h01, 5'h02, 16'h0, 1'b0, "R9 clearing frame");
        bus_read(5'h10, r); chk(r == 0, "R9 failure cleared", 64'(r), 0);
        wait_idle();

        repeat (10) @(negedge clk);
        chk(frames_seen == frames_sent && exp_q.size() == 0, "R7 frame count",
            64'(frames_seen), 64'(frames_sent));

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule